// File: doc/BRIEF.md
# Gated PWM Channel Bank with Startup Burst

This block drives a bank of outputs, each one paired with its own enable input. An output stays low while its enable is low. When the enable goes high, the output is held high for a startup burst that lasts a whole number of carrier periods. After the burst the output carries a fixed-duty PWM carrier. When the enable drops, the output returns low.

All channels share one free-running carrier counter. Each channel keeps its own three-state sequencer and its own burst counter, so the channels start and stop independently while staying phase-aligned to the common carrier. Carrier period, high time and burst length are elaboration-time parameters. The defaults give a 40 kHz carrier with 15% duty from a 48 MHz clock, and a burst of 20 carrier periods.

Because the burst is counted in carrier wraps, its length depends on the carrier phase at which the enable was seen. It therefore varies by up to one carrier period.

Top module: `gated_pwm_burst`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, every output is low. Reset sets the carrier counter to 0.
- R2: A channel whose enable has been low for at least three clocks drives its output low, with no carrier pulses.
- R3: An enable change reaches the output after exactly three rising clock edges: two synchronizer flops and one state register.
- R4: After a rising enable, the output is high for exactly STARTUP_PERIODS*PERIOD − c clocks of burst, where c is the carrier count on the first burst cycle. This lies between (STARTUP_PERIODS−1)*PERIOD+1 and STARTUP_PERIODS*PERIOD clocks.
- R5: The carrier counter runs 0 to PERIOD−1 and wraps. In PWM the output is high while the count is below HIGH_CNT and low otherwise, which gives HIGH_CNT high and PERIOD−HIGH_CNT low clocks per period.
- R6: PWM begins on the STARTUP_PERIODS-th carrier wrap of the burst. The first PWM period starts at count 0, so the burst's high time runs straight on into HIGH_CNT further high clocks.
- R7: A falling enable, in the burst or in PWM, makes the output low three clocks later and returns the channel to idle.
- R8: A new rising enable after a fall restarts the full burst, with the burst count cleared.
- R9: Channels act independently: activity on one channel leaves every idle channel's output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | NUM_CH | Per-channel enable, asynchronous to clk |
| pwm_o | output | NUM_CH | Per-channel output |

## Verification
The hardest cases to reach are the two ends of the burst-length range. They depend on the carrier phase at the moment the synchronized enable enters the burst, and that phase cannot be seen at the ports. The bench keeps its own count of cycles since reset to track the carrier phase. It raises the enable at chosen phases, so that the burst starts on count 0 and on count PERIOD−1. Small parameter values keep each burst short, and the bench measures the exact length of the high run that follows.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_KICK = 2'd1,
        CH_RUN  = 2'd2
    } ch_state_e;

    typedef struct packed {
        logic wrap;
        logic hi;
    } carrier_t;

endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/gpb_carrier.sv
module gpb_carrier
    import gpb_pkg::*;
#(
    parameter int PERIOD   = 1200,
    parameter int HIGH_CNT = 180
) (
    input  logic     clk,
    input  logic     rst,
    output carrier_t car_o
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
    localparam logic [CW-1:0] HCMP = CW'(HIGH_CNT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        car_o.wrap = (cnt_q == LAST);
        car_o.hi   = (cnt_q < HCMP);
    end

    assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == LAST) |=> (cnt_q == '0));
    assert_cnt_range_R5: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);
endmodule

// File: rtl/gpb_channel.sv
module gpb_channel
    import gpb_pkg::*;
#(
    parameter int STARTUP_PERIODS = 20
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     lvl_i,
    input  carrier_t car_i,
    output logic     out_o
);
    localparam int SW = $clog2(STARTUP_PERIODS + 1);
    localparam logic [SW-1:0] SLAST = SW'(STARTUP_PERIODS - 1);

    ch_state_e     state_q;
    logic [SW-1:0] scnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CH_IDLE;
            scnt_q  <= '0;
        end else begin
            unique case (state_q)
                CH_IDLE: begin
                    if (lvl_i) begin
                        state_q <= CH_KICK;
                        scnt_q  <= '0;
                    end
                end
                CH_KICK: begin
                    if (!lvl_i) begin
                        state_q <= CH_IDLE;
                        scnt_q  <= '0;
                    end else if (car_i.wrap) begin
                        if (scnt_q == SLAST) begin
                            state_q <= CH_RUN;
                            scnt_q  <= '0;
                        end else begin
                            scnt_q <= scnt_q + 1'b1;
                        end
                    end
                end
                CH_RUN: begin
                    if (!lvl_i) begin
                        state_q <= CH_IDLE;
                    end
                end
                default: begin
                    state_q <= CH_IDLE;
                    scnt_q  <= '0;
                end
            endcase
        end
    end

    assign out_o = (state_q == CH_KICK) || ((state_q == CH_RUN) && car_i.hi);

    assert_fall_low_R7: assert property (@(posedge clk) disable iff (rst)
        !lvl_i |=> !out_o);
    assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == CH_IDLE && lvl_i) |=> (state_q == CH_KICK && scnt_q == '0));
    assert_burst_bound_R4: assert property (@(posedge clk) disable iff (rst)
        scnt_q <= SLAST);
    assert_run_entry_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == CH_RUN && $past(state_q) != CH_RUN)
            |-> ($past(state_q) == CH_KICK && $past(car_i.wrap)));
endmodule

// File: rtl/gated_pwm_burst.sv
module gated_pwm_burst
    import gpb_pkg::*;
#(
    parameter int NUM_CH          = 5,
    parameter int PERIOD          = 1200,
    parameter int HIGH_CNT        = 180,
    parameter int STARTUP_PERIODS = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] en_i,
    output logic [NUM_CH-1:0] pwm_o
);
    carrier_t          car;
    logic [NUM_CH-1:0] lvl;

    gpb_sync #(.W(NUM_CH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (en_i),
        .q_o (lvl)
    );

    gpb_carrier #(.PERIOD(PERIOD), .HIGH_CNT(HIGH_CNT)) u_carrier (
        .clk   (clk),
        .rst   (rst),
        .car_o (car)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        gpb_channel #(.STARTUP_PERIODS(STARTUP_PERIODS)) u_ch (
            .clk   (clk),
            .rst   (rst),
            .lvl_i (lvl[g]),
            .car_i (car),
            .out_o (pwm_o[g])
        );
    end

    assert_reset_low_R1: assert property (@(posedge clk)
        rst |=> (pwm_o == '0));
endmodule

// File: tb/gated_pwm_burst_tb.sv
module gated_pwm_burst_tb;
    localparam int N = 5;
    localparam int P = 10;
    localparam int H = 3;
    localparam int S = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] en  = '0;
    logic [N-1:0] pwm;

    int  errors = 0;
    int  checks = 0;
    int  cyc    = 0;
    bit  done   = 0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    gated_pwm_burst #(.NUM_CH(N), .PERIOD(P), .HIGH_CNT(H), .STARTUP_PERIODS(S)) u_dut (
        .clk   (clk),
        .rst   (rst),
        .en_i  (en),
        .pwm_o (pwm)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_phase(input int ph);
        @(negedge clk);
        while ((cyc % P) != ph) @(negedge clk);
    endtask

    task automatic test_reset();
        rst = 1'b1;
        en  = '0;
        repeat (3) @(negedge clk);
        chk(pwm == '0, "R1 outputs low in reset", int'(pwm), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(pwm == '0, "R1 outputs low after reset", int'(pwm), 0);
        chk(cyc == 1, "R1 counter phase after reset", cyc, 1);
    endtask

    task automatic test_idle();
        int bad = 0;
        for (int i = 0; i < 3 * P; i++) begin
            @(negedge clk);
            if (pwm != '0) bad++;
        end
        chk(bad == 0, "R2 idle outputs low", bad, 0);
    endtask

    task automatic test_latency();
        en[0] = 1'b1;
        @(negedge clk); chk(pwm[0] == 1'b0, "R3 rise edge 1", pwm[0], 0);
        @(negedge clk); chk(pwm[0] == 1'b0, "R3 rise edge 2", pwm[0], 0);
        @(negedge clk); chk(pwm[0] == 1'b1, "R3 rise edge 3", pwm[0], 1);
        repeat (4) @(negedge clk);
        en[0] = 1'b0;
        @(negedge clk); chk(pwm[0] == 1'b1, "R3 fall edge 1", pwm[0], 1);
        @(negedge clk); chk(pwm[0] == 1'b1, "R3 fall edge 2", pwm[0], 1);
        @(negedge clk); chk(pwm[0] == 1'b0, "R7 fall edge 3 low", pwm[0], 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic measure_run(input int ch, input int drive_ph, input string tag);
        int c;
        int run;
        int low;
        int hi2;
        int others_bad;
        c = (drive_ph + 3) % P;
        wait_phase(drive_ph);
        en[ch] = 1'b1;
        repeat (3) @(negedge clk);
        chk(pwm[ch] == 1'b1, {tag, " R4 burst starts"}, pwm[ch], 1);
        run = 0;
        others_bad = 0;
        while (pwm[ch] && run < 2 * S * P) begin
            run++;
            if ((pwm & ~(N'(1) << ch)) != '0) others_bad++;
            @(negedge clk);
        end
        chk(run == S * P - c + H, {tag, " R4 R6 burst plus first high"}, run, S * P - c + H);
        low = 0;
        while (!pwm[ch] && low < 2 * P) begin
            low++;
            @(negedge clk);
        end
        chk(low == P - H, {tag, " R5 PWM low time"}, low, P - H);
        hi2 = 0;
        while (pwm[ch] && hi2 < 2 * P) begin
            hi2++;
            @(negedge clk);
        end
        chk(hi2 == H, {tag, " R5 PWM high time"}, hi2, H);
        chk(others_bad == 0, {tag, " R9 idle channels stay low"}, others_bad, 0);
        en[ch] = 1'b0;
        repeat (3) @(negedge clk);
        chk(pwm[ch] == 1'b0, {tag, " R7 low after fall in PWM"}, pwm[ch], 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic test_burst_ends();
        measure_run(1, P - 3, "max burst");
        measure_run(2, P - 4, "min burst");
    endtask

    task automatic test_fall_in_burst();
        en[3] = 1'b1;
        repeat (12) @(negedge clk);
        chk(pwm[3] == 1'b1, "R4 high mid burst", pwm[3], 1);
        en[3] = 1'b0;
        repeat (3) @(negedge clk);
        chk(pwm[3] == 1'b0, "R7 low after fall in burst", pwm[3], 0);
        repeat (2) @(negedge clk);
        measure_run(3, 2, "R8 restart");
    endtask

    task automatic test_fall_in_pwm_high();
        int guard = 0;
        en[4] = 1'b1;
        repeat (S * P + P + 3) @(negedge clk);
        while (!pwm[4] && guard < 2 * P) begin
            guard++;
            @(negedge clk);
        end
        chk(pwm[4] == 1'b1, "R5 PWM high seen", pwm[4], 1);
        en[4] = 1'b0;
        repeat (3) @(negedge clk);
        chk(pwm[4] == 1'b0, "R7 low after fall in PWM high", pwm[4], 0);
        repeat (P) @(negedge clk);
        chk(pwm[4] == 1'b0, "R2 stays low after fall", pwm[4], 0);
    endtask

    initial begin
        test_reset();
        test_idle();
        test_latency();
        test_burst_ends();
        test_fall_in_burst();
        test_fall_in_pwm_high();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule